// File: doc/BRIEF.md
# Predicated Execute Unit with Shifted Operand

This block is the execute stage of a small register machine in which every instruction carries a guard. A compare instruction records how two operands relate by setting exactly one of three status flags: above, same or below. Each later instruction looks at its guard and the current flags. If the guard holds, the instruction runs. If it does not, the instruction still uses its issue cycle but writes no register, changes no flag and does not redirect the program.

The second operand of add, subtract and compare passes through a left shifter. The shift amount is an immediate, so scaling an index needs no extra instruction. Branches are resolved here too. The unit reports a taken branch, and the fetch logic outside the block supplies the target. One instruction is accepted per clock. Its register write, flag update and branch decision are all registered and appear one cycle after issue. A register written by one instruction can be read by the very next one.

A compare, subtract-if-above, subtract-if-below, branch-if-unequal loop therefore converges to the greatest common divisor of two registers without any data-dependent branching inside the loop body.

Top module: `pred_exec_unit`

## Requirements
- R1: While reset is held and in the first cycle after reset, out_flags is 3'b010 (bit 2 above, bit 1 same, bit 0 below), and out_valid, out_pass, out_wen and out_branch are 0. All eight registers read as zero.
- R2: A compare (op 2) whose guard holds sets out_flags to exactly one set bit. The bit is chosen from an unsigned 32-bit comparison of rn against the shifted rm: bit 2 when greater, bit 1 when equal, bit 0 when less.
- R3: Guard codes are 0 always, 1 above, 2 same, 3 below and 4 not-same (same flag clear). Codes 5 to 15 never hold. When the guard fails, the instruction causes no register write, no flag change and no branch.
- R4: An add (op 0) writes rn + (rm << shamt) to rd, with shamt 0 to 31. Bits shifted past bit 31 are discarded, and the sum wraps modulo 2^32.
- R5: A subtract (op 1) writes rn - (rm << shamt) to rd, modulo 2^32.
- R6: Only a compare whose guard holds changes out_flags. All other instructions leave the flags unchanged.
- R7: A branch (op 4) raises out_branch for one cycle exactly when its guard holds. With guard 4 it is taken whenever the same flag is clear.
- R8: Each issued instruction raises out_valid in the following cycle, whether or not its guard holds, and out_pass reports the guard result. A cycle with no issue gives out_valid 0 in the next cycle.
- R9: A move-immediate (op 3) writes in_imm to rd.
- R10: A register written by one instruction supplies its new value to an instruction issued in the very next cycle.
- R11: With 48 and 18 in two registers, repeating compare, subtract-if-above, subtract-if-below, branch-if-unequal leaves both registers holding 6 when the branch is first not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is issued this cycle |
| in_op | input | 3 | Operation: 0 add, 1 sub, 2 compare, 3 move-immediate, 4 branch |
| in_cond | input | 4 | Guard code |
| in_rd | input | 3 | Destination register |
| in_rn | input | 3 | First source register |
| in_rm | input | 3 | Second source register (shifted) |
| in_shamt | input | 5 | Left shift amount for the second operand |
| in_imm | input | 32 | Immediate for move-immediate |
| out_valid | output | 1 | An instruction completed in the previous cycle |
| out_pass | output | 1 | Its guard held |
| out_wen | output | 1 | It wrote a register |
| out_waddr | output | 3 | Register written |
| out_wdata | output | 32 | Value written |
| out_branch | output | 1 | Branch taken |
| out_flags | output | 3 | Current flags {above, same, below} |

## Verification
On every cycle the assertions check four things: the flags stay one-hot, a failed guard never produces a write or a branch and leaves the flags steady, flags change only after a compare, and each issue yields exactly one completion a cycle later. Whether a written value is arithmetically right cannot be seen by those properties. The bench's scenarios show it: shifted adds that overflow, wrapping subtracts, every guard code against every flag state, back-to-back dependent instructions, and the full divisor loop. Each one is compared against the reference model.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_MOVI = 3'd3,
    OP_BR   = 3'd4
  } pe_op_e;

  typedef enum logic [3:0] {
    G_ALWAYS = 4'd0,
    G_ABOVE  = 4'd1,
    G_SAME   = 4'd2,
    G_BELOW  = 4'd3,
    G_DIFF   = 4'd4
  } pe_guard_e;

  localparam int FL_ABOVE = 2;
  localparam int FL_SAME  = 1;
  localparam int FL_BELOW = 0;
  localparam logic [2:0] FLAGS_RESET = 3'b010;
endpackage

// File: rtl/pe_regfile.sv
module pe_regfile #(
  parameter int N = 8,
  parameter int W = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] cells [N];

  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        cells[i] <= '0;
      else if (we && (wa == AW'(i)))
        cells[i] <= wd;
    end
  end

  assign rd_a = cells[ra_a];
  assign rd_b = cells[ra_b];
endmodule

// File: rtl/pe_guard.sv
module pe_guard
  import pe_pkg::*;
(
  input  logic [3:0] guard,
  input  logic [2:0] flags,
  output logic       holds
);
  function automatic logic guard_eval(input logic [3:0] g, input logic [2:0] f);
    case (pe_guard_e'(g))
      G_ALWAYS: return 1'b1;
      G_ABOVE:  return f[FL_ABOVE];
      G_SAME:   return f[FL_SAME];
      G_BELOW:  return f[FL_BELOW];
      G_DIFF:   return !f[FL_SAME];
      default:  return 1'b0;
    endcase
  endfunction

  assign holds = guard_eval(guard, flags);
endmodule

// File: rtl/pe_shift_alu.sv
module pe_shift_alu
  import pe_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [2:0]    op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b_raw,
  input  logic [SW-1:0] shamt,
  input  logic [W-1:0]  imm,
  output logic [W-1:0]  result,
  output logic [2:0]    rel
);
  function automatic logic [W-1:0] scale(input logic [W-1:0] v, input logic [SW-1:0] s);
    return v << s;
  endfunction

  function automatic logic [2:0] relate(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2:0] f;
    f = '0;
    if (x > y)       f[FL_ABOVE] = 1'b1;
    else if (x == y) f[FL_SAME]  = 1'b1;
    else             f[FL_BELOW] = 1'b1;
    return f;
  endfunction

  logic [W-1:0] b_sh;
  assign b_sh = scale(b_raw, shamt);
  assign rel  = relate(a, b_sh);

  always_comb begin
    case (pe_op_e'(op))
      OP_ADD:  result = a + b_sh;
      OP_SUB:  result = a - b_sh;
      OP_MOVI: result = imm;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit
  import pe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  localparam int AW = $clog2(REG_N),
  localparam int SW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [3:0]        in_cond,
  input  logic [AW-1:0]     in_rd,
  input  logic [AW-1:0]     in_rn,
  input  logic [AW-1:0]     in_rm,
  input  logic [SW-1:0]     in_shamt,
  input  logic [DATA_W-1:0] in_imm,
  output logic              out_valid,
  output logic              out_pass,
  output logic              out_wen,
  output logic [AW-1:0]     out_waddr,
  output logic [DATA_W-1:0] out_wdata,
  output logic              out_branch,
  output logic [2:0]        out_flags
);
  logic [DATA_W-1:0] op_a, op_b, alu_res;
  logic [2:0]        rel;
  logic              guard_holds;

  // named events for the checker
  logic guard_ok, do_write, do_flags, do_branch;

  pe_regfile #(.N(REG_N), .W(DATA_W)) i_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(in_rn), .ra_b(in_rm), .rd_a(op_a), .rd_b(op_b),
    .we(do_write), .wa(in_rd), .wd(alu_res)
  );

  pe_guard i_guard (.guard(in_cond), .flags(out_flags), .holds(guard_holds));

  pe_shift_alu #(.W(DATA_W)) i_alu (
    .op(in_op), .a(op_a), .b_raw(op_b), .shamt(in_shamt),
    .imm(in_imm), .result(alu_res), .rel(rel)
  );

  assign guard_ok  = in_valid && guard_holds;
  assign do_write  = guard_ok && (in_op == OP_ADD || in_op == OP_SUB || in_op == OP_MOVI);
  assign do_flags  = guard_ok && (in_op == OP_CMP);
  assign do_branch = guard_ok && (in_op == OP_BR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_flags  <= FLAGS_RESET;
      out_valid  <= 1'b0;
      out_pass   <= 1'b0;
      out_wen    <= 1'b0;
      out_waddr  <= '0;
      out_wdata  <= '0;
      out_branch <= 1'b0;
    end else begin
      if (do_flags) out_flags <= rel;
      out_valid  <= in_valid;
      out_pass   <= guard_ok;
      out_wen    <= do_write;
      out_waddr  <= do_write ? in_rd : '0;
      out_wdata  <= do_write ? alu_res : '0;
      out_branch <= do_branch;
    end
  end
endmodule

// File: rtl/pe_checker.sv
module pe_checker
  import pe_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [2:0] in_op,
  input logic       out_valid,
  input logic       out_pass,
  input logic       out_wen,
  input logic       out_branch,
  input logic [2:0] out_flags,
  input logic       do_write,
  input logic       do_flags
);
  AST_FLAGS_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_flags) == 1); // R2

  AST_SKIP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_pass) |-> (!out_wen && !out_branch)); // R3

  AST_SKIP_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_pass) |-> $stable(out_flags)); // R3

  AST_FLAGS_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_flags) |-> $past(in_valid && in_op == OP_CMP)); // R6

  AST_CMP_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    do_flags |=> (out_valid && out_pass && !out_wen)); // R6

  AST_BRANCH_FROM_BR: assert property (@(posedge clk) disable iff (!rst_n)
    out_branch |-> (out_pass && $past(in_op) == OP_BR)); // R7

  AST_ISSUE_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_wen && !out_branch)); // R8

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> out_wen); // R4
endmodule

bind pred_exec_unit pe_checker i_pe_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .out_valid(out_valid), .out_pass(out_pass), .out_wen(out_wen),
  .out_branch(out_branch), .out_flags(out_flags),
  .do_write(do_write), .do_flags(do_flags)
);

// File: tb/test_pred_exec_unit.sv
module test_pred_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [3:0]  in_cond = '0;
  logic [2:0]  in_rd = '0, in_rn = '0, in_rm = '0;
  logic [4:0]  in_shamt = '0;
  logic [31:0] in_imm = '0;
  logic        out_valid, out_pass, out_wen, out_branch;
  logic [2:0]  out_waddr, out_flags;
  logic [31:0] out_wdata;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  // reference state
  logic [31:0] m_reg [8];
  logic [2:0]  m_flags;

  always #2.5 clk = ~clk;

  pred_exec_unit i_pred_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_cond(in_cond), .in_rd(in_rd), .in_rn(in_rn), .in_rm(in_rm),
    .in_shamt(in_shamt), .in_imm(in_imm), .out_valid(out_valid),
    .out_pass(out_pass), .out_wen(out_wen), .out_waddr(out_waddr),
    .out_wdata(out_wdata), .out_branch(out_branch), .out_flags(out_flags)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        summary();
      end
    end
  end

  function automatic bit m_guard(input logic [3:0] g);
    if (g == 4'd0) return 1;
    if (g == 4'd1) return m_flags == 3'b100;
    if (g == 4'd2) return m_flags == 3'b010;
    if (g == 4'd3) return m_flags == 3'b001;
    if (g == 4'd4) return m_flags != 3'b010;
    return 0;
  endfunction

  function automatic logic [31:0] m_scale(input logic [31:0] v, input int s);
    logic [31:0] r = v;
    for (int k = 0; k < s; k++) r = r * 32'd2;
    return r;
  endfunction

  // issue one instruction, predict, then compare all outputs after the edge
  task automatic issue(input string req, input int op, input int g, input int rd,
                       input int rn, input int rm, input int sh, input logic [31:0] imm,
                       output bit taken);
    bit p, w, br;
    logic [31:0] val, bs;
    in_valid = 1; in_op = 3'(op); in_cond = 4'(g); in_rd = 3'(rd);
    in_rn = 3'(rn); in_rm = 3'(rm); in_shamt = 5'(sh); in_imm = imm;
    p = m_guard(4'(g));
    bs = m_scale(m_reg[rm], sh);
    w = 0; br = 0; val = 0;
    if (p) begin
      case (op)
        0: begin w = 1; val = m_reg[rn] + bs; end
        1: begin w = 1; val = m_reg[rn] - bs; end
        2: m_flags = (m_reg[rn] > bs) ? 3'b100 : (m_reg[rn] == bs) ? 3'b010 : 3'b001;
        3: begin w = 1; val = imm; end
        4: br = 1;
        default: ;
      endcase
    end
    @(negedge clk);
    if (w) m_reg[rd] = val;
    check(req, "valid", 32'(out_valid), 32'd1);
    check(req, "pass", 32'(out_pass), 32'(p));
    check(req, "wen", 32'(out_wen), 32'(w));
    if (w) begin
      check(req, "waddr", 32'(out_waddr), 32'(rd));
      check(req, "wdata", out_wdata, val);
    end
    check(req, "branch", 32'(out_branch), 32'(br));
    check(req, "flags", 32'(out_flags), 32'(m_flags));
    taken = br;
  endtask

  task automatic idle(input string req);
    in_valid = 0;
    @(negedge clk);
    check(req, "idle valid", 32'(out_valid), 32'd0);
    check(req, "idle wen", 32'(out_wen), 32'd0);
    check(req, "idle flags", 32'(out_flags), 32'(m_flags));
  endtask

  initial begin
    bit t;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_flags = 3'b010;
    repeat (3) @(negedge clk);
    // R1 during reset and after release
    check("R1", "flags in reset", 32'(out_flags), 32'h2);
    check("R1", "valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "flags after reset", 32'(out_flags), 32'h2);
    check("R1", "branch after reset", 32'(out_branch), 32'd0);
    issue("R1", 0, 0, 7, 5, 6, 0, 0, t);          // r7 = r5 + r6 = 0
    check("R1", "reset registers sum", out_wdata, 32'd0);

    // R9 and R10: loads feeding the very next instruction
    issue("R9", 3, 0, 1, 0, 0, 0, 32'd48, t);
    issue("R9", 3, 0, 2, 0, 0, 0, 32'd18, t);
    issue("R10", 0, 0, 3, 1, 2, 0, 0, t);        // 66 from both just-written
    check("R10", "back-to-back sum", out_wdata, 32'd66);

    // R4 shifted add and discarded bits
    issue("R4", 0, 0, 3, 1, 2, 2, 0, t);
    check("R4", "48 + 18<<2", out_wdata, 32'd120);
    issue("R9", 3, 0, 4, 0, 0, 0, 32'h0000_0003, t);
    issue("R4", 0, 0, 5, 0, 4, 31, 0, t);
    check("R4", "3<<31 drops top bit", out_wdata, 32'h8000_0000);
    issue("R9", 3, 0, 6, 0, 0, 0, 32'hFFFF_FFFF, t);
    issue("R4", 0, 0, 5, 6, 4, 0, 0, t);
    check("R4", "wrapped sum", out_wdata, 32'h0000_0002);

    // R5 subtract wraps
    issue("R5", 1, 0, 5, 2, 1, 0, 0, t);
    check("R5", "18-48", out_wdata, 32'hFFFF_FFE2);
    issue("R5", 1, 0, 5, 3, 4, 3, 0, t);
    check("R5", "120 - 3<<3", out_wdata, 32'd96);

    // R2 compare outcomes, unsigned
    issue("R2", 2, 0, 0, 1, 2, 0, 0, t);
    check("R2", "48 vs 18", 32'(out_flags), 32'h4);
    issue("R2", 2, 0, 0, 6, 1, 0, 0, t);
    check("R2", "unsigned max above", 32'(out_flags), 32'h4);
    issue("R2", 2, 0, 0, 1, 4, 4, 0, t);         // 48 vs 3<<4
    check("R2", "equal via shift", 32'(out_flags), 32'h2);
    issue("R2", 2, 0, 0, 2, 1, 0, 0, t);
    check("R2", "18 vs 48", 32'(out_flags), 32'h1);

    // R3 every guard code under 'below'
    for (int g = 0; g < 16; g++) issue("R3", 0, g, 7, 1, 2, 0, 0, t);
    issue("R3", 2, 1, 0, 1, 2, 0, 0, t);         // failed compare: flags stay below
    check("R3", "failed compare keeps flags", 32'(out_flags), 32'h1);
    issue("R3", 3, 2, 1, 0, 0, 0, 32'd999, t);   // skipped move
    issue("R3", 0, 0, 7, 1, 0, 0, 0, t);
    check("R3", "r1 untouched", out_wdata, 32'd48);

    // R6 non-compare leaves flags
    issue("R6", 1, 0, 7, 1, 2, 0, 0, t);
    check("R6", "flags after sub", 32'(out_flags), 32'h1);

    // R7 branch with not-same guard
    issue("R7", 4, 4, 0, 0, 0, 0, 0, t);
    check("R7", "taken when below", 32'(t), 32'd1);
    issue("R7", 2, 0, 0, 1, 1, 0, 0, t);
    issue("R7", 4, 4, 0, 0, 0, 0, 0, t);
    check("R7", "not taken when same", 32'(out_branch), 32'd0);
    issue("R7", 4, 2, 0, 0, 0, 0, 0, t);
    check("R7", "same guard taken", 32'(out_branch), 32'd1);

    // R8 idle gaps
    idle("R8");
    idle("R8");

    // R11 divisor loop on r1=48, r2=18
    issue("R11", 3, 0, 1, 0, 0, 0, 32'd48, t);
    issue("R11", 3, 0, 2, 0, 0, 0, 32'd18, t);
    for (int it = 0; it < 60; it++) begin
      issue("R11", 2, 0, 0, 1, 2, 0, 0, t);
      issue("R11", 1, 1, 1, 1, 2, 0, 0, t);
      issue("R11", 1, 3, 2, 2, 1, 0, 0, t);
      issue("R11", 4, 4, 0, 0, 0, 0, 0, t);
      if (!t) break;
    end
    check("R11", "loop ended", 32'(out_branch), 32'd0);
    issue("R11", 0, 0, 7, 1, 0, 0, 0, t);
    check("R11", "r1 divisor", out_wdata, 32'd6);
    issue("R11", 0, 0, 7, 2, 0, 0, 0, t);
    check("R11", "r2 divisor", out_wdata, 32'd6);
    idle("R8");
    summary();
  end
endmodule